// File: doc/BRIEF.md
# Serial-Fed Quadrature Mouse Counters

This block tracks the motion of two pointing devices whose quadrature lines are not wired to it directly. The lines go to an external parallel-in, serial-out shift register. The block pulses a load strobe so that the converter latches all eight lines together. It then clocks the eight bits out one at a time, capturing each bit on the rising edge of its own serial clock. Once a whole frame has arrived, the decoded phase of every axis is applied in a single cycle.

There are four axes: horizontal and vertical on each of the two ports. Each axis keeps a 6-bit motion count that moves one step for each full quadrature cycle, plus a 2-bit live phase. Each port has a 16-bit read word that packs both axes. Because the low two bits always show the current input phase, a digital joystick on the same pins can be decoded from them. The forward/back and left/right switches are read through XOR and plain bit tests.

A broadcast test write presets the count field of all four axes at once.

Top module: `quad_mouse_counters`

## Requirements
- R1: Each port word holds the vertical axis in bits 15..8 and the horizontal axis in bits 7..0. Within an axis byte, bits 7..2 are the motion count and bits 1..0 are the live phase.
- R2: `load_o` is high for exactly one clock at the start of each frame, and a frame lasts 17 clocks.
- R3: In each frame `ser_clk_o` gives 8 pulses, each one clock wide, and is never high while `load_o` is high. `ser_data_i` is captured on the clock edge at which `ser_clk_o` rises.
- R4: The captured bits are consumed in this order, first to last: port 0 horizontal clock, port 0 horizontal quadrature, port 0 vertical clock, port 0 vertical quadrature, then the same four for port 1.
- R5: An axis phase is {clock, clock xor quadrature}. The port words change only on the clock edge that ends the 17th cycle of a frame, or on a test write.
- R6: A phase change from 3 to 0 increments that axis count by one.
- R7: A phase change from 0 to 3 decrements that axis count by one.
- R8: A phase jump of two steps, or no change, leaves the count as it was.
- R9: The counts wrap modulo 64 in both directions without saturating.
- R10: When `test_we_i` is high at a clock edge, every vertical count loads `test_data_i[15:10]` and every horizontal count loads `test_data_i[7:2]`. Bits 9..8 and 1..0 of the word have no effect, and all phases are kept.
- R11: When a test write meets a frame update on the same edge, the written value wins for the counts and the phases still take the new frame values.
- R12: Reset sets both port words to zero, and the first cycle after reset is a load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_data_i | input | 1 | Serial bit from the external converter |
| load_o | output | 1 | Parallel-load strobe for the converter |
| ser_clk_o | output | 1 | Shift clock for the converter |
| test_we_i | input | 1 | Broadcast test write enable |
| test_data_i | input | 16 | Test write word |
| joy0_o | output | 16 | Port 0 read word |
| joy1_o | output | 16 | Port 1 read word |

## Verification
The bench builds the block with its default 6-bit counts. This keeps every field position of the read and test words at the 16-bit layout above, and a full wrap takes only 64 forward quadrature cycles, or a little over 4,000 clocks. That brings both the 63-to-0 wrap and the write-during-update collision within a short run. Single-bit walking frames expose any mistake in serial order, and mixed forward and backward patterns exercise both count directions on each port.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef logic [1:0] phase_t;

  function automatic phase_t to_phase(input logic clk_in, input logic quad_in);
    return {clk_in, clk_in ^ quad_in};
  endfunction
endpackage

// File: rtl/mq_ser_rx.sv
module mq_ser_rx #(
  parameter int FBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_data_i,
  output logic             load_o,
  output logic             ser_clk_o,
  output logic [FBITS-1:0] frame_o,
  output logic             frame_vld_o
);
  localparam int LEN = 2 * FBITS + 1;
  localparam int CW  = $clog2(LEN);

  logic [CW-1:0]    cnt_q;
  logic [FBITS-1:0] shreg_q;
  logic             vld_q;

  // cycle 0 loads, odd cycles capture, even cycles hold the serial clock high
  assign load_o      = (cnt_q == '0);
  assign ser_clk_o   = (cnt_q != '0) && !cnt_q[0];
  assign frame_o     = shreg_q;
  assign frame_vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CW'(LEN - 1)) ? '0 : cnt_q + 1'b1;
      vld_q <= (cnt_q == CW'(LEN - 2));
      for (int i = 0; i < FBITS; i++) begin
        if (cnt_q == CW'(2 * i + 1)) shreg_q[i] <= ser_data_i;
      end
    end
  end
endmodule

// File: rtl/mq_axis.sv
module mq_axis
  import mq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             clk_in_i,
  input  logic             quad_in_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W+1:0] val_o
);
  phase_t           ph_q, ph_new;
  logic [CNT_W-1:0] cnt_q;
  logic             inc, dec;

  assign ph_new = to_phase(clk_in_i, quad_in_i);
  assign inc    = upd_i && (ph_q == 2'd3) && (ph_new == 2'd0);
  assign dec    = upd_i && (ph_q == 2'd0) && (ph_new == 2'd3);
  assign val_o  = {cnt_q, ph_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      if (wr_i)     cnt_q <= wr_val_i;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      else if (dec) cnt_q <= cnt_q - 1'b1;
      if (upd_i) ph_q <= ph_new;
    end
  end
endmodule

// File: rtl/quad_mouse_counters.sv
module quad_mouse_counters #(
  parameter int CNT_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ser_data_i,
  output logic                     load_o,
  output logic                     ser_clk_o,
  input  logic                     test_we_i,
  input  logic [2*(CNT_W+2)-1:0]   test_data_i,
  output logic [2*(CNT_W+2)-1:0]   joy0_o,
  output logic [2*(CNT_W+2)-1:0]   joy1_o
);
  localparam int NAXES = 4;
  localparam int FBITS = 2 * NAXES;
  localparam int AXW   = CNT_W + 2;
  localparam int REG_W = 2 * AXW;

  logic [FBITS-1:0] frame_w;
  logic             frame_vld_w;
  logic [AXW-1:0]   axis_val [NAXES];

  mq_ser_rx #(.FBITS(FBITS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_data_i (ser_data_i),
    .load_o     (load_o),
    .ser_clk_o  (ser_clk_o),
    .frame_o    (frame_w),
    .frame_vld_o(frame_vld_w)
  );

  // axis 2p = port p horizontal, 2p+1 = port p vertical
  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic [CNT_W-1:0] wr_val;
    if (a % 2 == 1) begin : g_vert
      assign wr_val = test_data_i[REG_W-1 -: CNT_W];
    end else begin : g_horz
      assign wr_val = test_data_i[AXW-1 -: CNT_W];
    end
    mq_axis #(.CNT_W(CNT_W)) u_axis (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (frame_vld_w),
      .clk_in_i (frame_w[2*a]),
      .quad_in_i(frame_w[2*a+1]),
      .wr_i     (test_we_i),
      .wr_val_i (wr_val),
      .val_o    (axis_val[a])
    );
  end

  assign joy0_o = {axis_val[1], axis_val[0]};
  assign joy1_o = {axis_val[3], axis_val[2]};
endmodule

// File: rtl/mq_checker.sv
module mq_checker #(
  parameter int CNT_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   load_o,
  input logic                   ser_clk_o,
  input logic                   test_we_i,
  input logic [2*(CNT_W+2)-1:0] test_data_i,
  input logic [2*(CNT_W+2)-1:0] joy0_o,
  input logic [2*(CNT_W+2)-1:0] joy1_o,
  input logic [7:0]             frame,
  input logic                   frame_vld
);
  localparam int AXW   = CNT_W + 2;
  localparam int REG_W = 2 * AXW;

  assert_load_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_sclk_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o |=> !ser_clk_o);

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_vld && !test_we_i) |=> ($stable(joy0_o) && $stable(joy1_o)));

  assert_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld |=> joy1_o[AXW+1:AXW] == {$past(frame[6]), $past(frame[6] ^ frame[7])});

  assert_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && !test_we_i && joy0_o[1:0] == 2'd3 && frame[1:0] == 2'b00)
    |=> joy0_o[AXW-1:2] == CNT_W'($past(joy0_o[AXW-1:2]) + 1'b1));

  assert_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && !test_we_i && joy0_o[1:0] == 2'd0 && frame[1:0] == 2'b01)
    |=> joy0_o[AXW-1:2] == CNT_W'($past(joy0_o[AXW-1:2]) - 1'b1));

  assert_twrite_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_we_i |=> (joy1_o[REG_W-1 -: CNT_W] == $past(test_data_i[REG_W-1 -: CNT_W]))
              && (joy0_o[AXW-1 -: CNT_W] == $past(test_data_i[AXW-1 -: CNT_W])));
endmodule

bind quad_mouse_counters mq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_o     (load_o),
  .ser_clk_o  (ser_clk_o),
  .test_we_i  (test_we_i),
  .test_data_i(test_data_i),
  .joy0_o     (joy0_o),
  .joy1_o     (joy1_o),
  .frame      (frame_w),
  .frame_vld  (frame_vld_w)
);

// File: tb/quad_mouse_counters_bench.sv
module quad_mouse_counters_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        ser_data, load, sclk, twe;
  logic [15:0] tdata, j0, j1;
  logic [7:0]  frame_in;
  logic [7:0]  conv = '0;
  int total = 0, bad = 0;

  quad_mouse_counters u_quad_mouse_counters (
    .clk_i(clk), .rst_ni(rst_n), .ser_data_i(ser_data), .load_o(load),
    .ser_clk_o(sclk), .test_we_i(twe), .test_data_i(tdata),
    .joy0_o(j0), .joy1_o(j1)
  );

  // external converter model
  assign ser_data = conv[0];
  always @(posedge clk) begin
    if (load)      conv <= frame_in;
    else if (sclk) conv <= {1'b0, conv[7:1]};
  end

  typedef struct {
    int          tag;
    logic [15:0] e0;
    logic [15:0] e1;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  int   load_seen = 0;

  logic [5:0] m_up [4];
  logic [1:0] m_ph [4];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_i(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] a0, input logic [1:0] a1,
                                    input logic [1:0] a2, input logic [1:0] a3);
    logic [1:0] p [4];
    logic [7:0] f;
    p = '{a0, a1, a2, a3};
    for (int i = 0; i < 4; i++) begin
      f[2*i]   = p[i][1];
      f[2*i+1] = p[i][1] ^ p[i][0];
    end
    return f;
  endfunction

  task automatic model_frame(input logic [7:0] f);
    for (int a = 0; a < 4; a++) begin
      logic [1:0] np;
      np = {f[2*a], f[2*a] ^ f[2*a+1]};
      if (m_ph[a] == 2'd3 && np == 2'd0)      m_up[a] = m_up[a] + 6'd1;
      else if (m_ph[a] == 2'd0 && np == 2'd3) m_up[a] = m_up[a] - 6'd1;
      m_ph[a] = np;
    end
  endtask

  task automatic model_write(input logic [15:0] d);
    for (int a = 0; a < 4; a++) m_up[a] = (a % 2 == 1) ? d[15:10] : d[7:2];
  endtask

  // mode 0: plain frame; 1: test write at load edge; 2: test write on update edge
  task automatic send(input logic [7:0] f, input int mode, input logic [15:0] d, input string req);
    exp_t e;
    do @(negedge clk); while (!load);
    frame_in = f;
    twe      = (mode == 1);
    tdata    = d;
    if (mode == 1) model_write(d);
    model_frame(f);
    if (mode == 2) model_write(d);
    e.tag = load_seen;
    e.e0  = {m_up[1], m_ph[1], m_up[0], m_ph[0]};
    e.e1  = {m_up[3], m_ph[3], m_up[2], m_ph[2]};
    e.req = req;
    exp_q.push_back(e);
    if (mode == 1) begin
      @(negedge clk);
      twe = 1'b0;
    end
    if (mode == 2) begin
      repeat (16) @(negedge clk);
      twe = 1'b1;
    end
  endtask

  // scoreboard monitor: results of a frame are visible at the next load cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && load) begin
        #1;
        if (exp_q.size() > 0 && exp_q[0].tag < load_seen) begin
          e = exp_q.pop_front();
          chk(e.req, j0, e.e0);
          chk(e.req, j1, e.e1);
        end
        load_seen++;
      end
    end
  end

  // strobe and serial clock timing
  int gap = 0, hi = 0, nfr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (load && sclk) begin
        total++; bad++;
        $display("FAIL R3 act=load+sclk exp=exclusive");
      end
      if (load) begin
        if (nfr > 0 && nfr < 6) begin
          chk_i("R2 frame length", gap, 17);
          chk_i("R3 serial pulses", hi, 8);
        end
        nfr++;
        gap = 1;
        hi  = 0;
      end else begin
        gap++;
        if (sclk) hi++;
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; twe = 1'b0; tdata = '0; frame_in = '0;
    for (int a = 0; a < 4; a++) begin m_up[a] = '0; m_ph[a] = '0; end
    repeat (3) @(negedge clk);
    chk("R12 reset port0", j0, 16'h0000);
    chk("R12 reset port1", j1, 16'h0000);
    chk_i("R12 load in reset", int'(load), 1);
    rst_n = 1'b1;

    send(8'h00, 0, 16'h0, "R1");
    for (int i = 0; i < 8; i++) begin
      send(8'(1 << i), 0, 16'h0, "R4");
      send(8'h00, 0, 16'h0, "R4");
    end
    for (int s = 1; s <= 8; s++) begin
      logic [1:0] p;
      p = 2'(s % 4);
      send(mk(p, p, p, p), 0, 16'h0, "R6");
    end
    for (int k = 1; k <= 8; k++) begin
      logic [1:0] pf, pb;
      pf = 2'(k % 4);
      pb = 2'((4 - k % 4) % 4);
      send(mk(pf, pb, pb, pf), 0, 16'h0, "R7");
    end
    send(mk(2, 2, 2, 2), 0, 16'h0, "R8");
    send(mk(0, 0, 0, 0), 0, 16'h0, "R8");
    send(mk(0, 2, 0, 2), 0, 16'h0, "R8");
    send(mk(1, 0, 3, 0), 0, 16'h0, "R8");
    send(mk(3, 2, 1, 2), 0, 16'h0, "R8");
    send(mk(0, 0, 0, 0), 0, 16'h0, "R8");
    for (int k = 1; k <= 260; k++) begin
      logic [1:0] p, r;
      p = 2'(k % 4);
      r = 2'((4 - k % 4) % 4);
      send(mk(p, 0, r, 0), 0, 16'h0, "R9");
    end
    send(mk(1, 2, 3, 1), 1, 16'hA7F3, "R10");
    send(mk(1, 2, 3, 1), 0, 16'h0, "R10");
    send(mk(2, 3, 3, 1), 1, 16'h5E2D, "R10");
    send(mk(3, 0, 3, 0), 0, 16'h0, "R11");
    send(mk(0, 3, 0, 3), 2, 16'h1234, "R11");
    send(mk(0, 3, 0, 3), 0, 16'h0, "R11");

    @(negedge clk);
    twe = 1'b0;
    repeat (40) @(negedge clk);
    chk_i("R5 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule